// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This unit sits beside the pipeline of a 64-bit processor. When the pipeline raises an exception, the unit picks the address of the handler and updates the state that the handler reads. That state is the cause fields, the saved exception PC and the exception-level flag. The pipeline sends the exception code, the coprocessor number, the faulting PC and three qualifiers: a delay-slot flag, a TLB-refill flag and a 64-bit-mode flag. A separate reset/NMI request forces the restart address.

The redirect is combinational, so the pipeline can steer fetch in the cycle the request is raised. No delay slot runs before the handler starts. The register updates commit at the clock edge that ends that same cycle.

The handler address comes from three things: the boot-vector selector (status bit 22), the exception level that was current before the request, and, for TLB refills, the addressing width. Each 32-bit vector is sign-extended to 64 bits. The return-from-exception logic lives elsewhere and drops the exception level through a single clear input.

Top module: `exc_entry_unit`

## Requirements
- R1: While `exc_req` is high and `rst_nmi_req` is low, `redirect_valid` is 1 and `redirect_pc` holds the handler vector in that same cycle. With neither request high, `redirect_valid` is 0.
- R2: `rst_nmi_req` forces `redirect_pc` to 0xFFFFFFFF_BFC00000, whatever the other inputs are. It wins over `exc_req`, and it leaves the cause, EPC and exception level unchanged.
- R3: With `boot_vec_sel`=0, the vectors are as follows. A TLB refill at exception level 0 goes to 0xFFFFFFFF_80000000 in 32-bit mode and to 0xFFFFFFFF_80000080 in 64-bit mode. Every other exception goes to 0xFFFFFFFF_80000180.
- R4: With `boot_vec_sel`=1, the same selection uses 0xFFFFFFFF_BFC00200, 0xFFFFFFFF_BFC00280 and 0xFFFFFFFF_BFC00380.
- R5: An accepted exception writes cause bit 31 to the value of `in_delay_slot`.
- R6: An accepted exception taken at exception level 0 writes `epc`. The value is `cur_pc`, or `cur_pc` minus 4 when `in_delay_slot` is 1. When the exception level is already 1, `epc` is unchanged.
- R7: An accepted exception sets `exl` to 1. `eret_clr` clears `exl` only when no exception is accepted in the same cycle.
- R8: An accepted exception loads `exc_code` into cause bits 6:2. For example, code 8 gives a cause value of 0x20.
- R9: Cause bits 29:28 take `cop_num` only when the code is 11 (coprocessor unusable). For any other code they keep their previous value.
- R10: With no request and no clear, `epc`, `exl` and `cause_word` hold their values.
- R11: After reset, `epc` is 0, `exl` is 0 and `cause_word` is 0. All cause bits that are not named here read 0.
- R12: Bits 63:32 of `redirect_pc` are always copies of bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Exception code |
| cop_num | input | 2 | Coprocessor that faulted |
| cur_pc | input | 64 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| tlb_refill | input | 1 | Exception is a TLB refill |
| mode64 | input | 1 | 64-bit addressing is active |
| rst_nmi_req | input | 1 | Reset or NMI request |
| boot_vec_sel | input | 1 | Boot-vector selector (status bit 22) |
| eret_clr | input | 1 | Clear the exception level |
| redirect_valid | output | 1 | Fetch redirect is active this cycle |
| redirect_pc | output | 64 | Sign-extended handler address |
| epc | output | 64 | Saved exception PC |
| exl | output | 1 | Exception level |
| cause_word | output | 32 | Cause register image |

## Verification
A wrong exception level does not stay hidden. It shows in the very next request: a TLB refill lands at offset 0x180 instead of 0x000 or 0x080, and `epc` either gets overwritten or stays stale. Both are visible one edge after the request. A bad delay-slot offset or a misplaced cause field shows in `epc` or `cause_word` at the edge that ends the request cycle. A vector fault shows on `redirect_pc` in the request cycle itself. The bench therefore mixes the vector selector, the exception level and the refill width, and checks the registers right after each commit edge.

// File: rtl/exc_entry_pkg.sv
// Package: shared constants for the exception entry unit.
// Assumes a 32-bit cause image and 32-bit vectors that are sign-extended later.
package exc_entry_pkg;
    localparam int CAUSE_W      = 32;
    localparam int CAUSE_BD_BIT = 31;
    localparam int CAUSE_CE_LSB = 28;
    localparam int CAUSE_EC_LSB = 2;
    localparam int EXC_CODE_CPU = 11;

    localparam logic [31:0] VEC_RESET     = 32'hBFC0_0000;
    localparam logic [31:0] VEC_BASE_NORM = 32'h8000_0000;
    localparam logic [31:0] VEC_BASE_BOOT = 32'hBFC0_0200;
    localparam logic [31:0] OFS_REFILL32  = 32'h0000_0000;
    localparam logic [31:0] OFS_REFILL64  = 32'h0000_0080;
    localparam logic [31:0] OFS_GENERAL   = 32'h0000_0180;
endpackage

// File: rtl/exc_vec_sel.sv
// Module: picks the handler vector and sign-extends it to XLEN bits.
// Assumes exl_cur is the exception level before the request commits.
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VEC_W = 32
) (
    input  logic            boot_vec_sel,
    input  logic            exl_cur,
    input  logic            tlb_refill,
    input  logic            mode64,
    input  logic            rst_nmi_req,
    output logic [XLEN-1:0] vec_out
);
    localparam int EXT_W = XLEN - VEC_W;

    logic [VEC_W-1:0] base;
    logic [VEC_W-1:0] ofs;
    logic [VEC_W-1:0] vec32;

    // Choose base and offset from the selector, the level and the refill width.
    always_comb begin
        base = boot_vec_sel ? VEC_W'(VEC_BASE_BOOT) : VEC_W'(VEC_BASE_NORM);
        if (tlb_refill && !exl_cur)
            ofs = mode64 ? VEC_W'(OFS_REFILL64) : VEC_W'(OFS_REFILL32);
        else
            ofs = VEC_W'(OFS_GENERAL);
        vec32 = rst_nmi_req ? VEC_W'(VEC_RESET) : (base + ofs);
    end

    generate
        if (EXT_W > 0) begin : g_ext
            assign vec_out = {{EXT_W{vec32[VEC_W-1]}}, vec32};
        end else begin : g_noext
            assign vec_out = vec32[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/exc_epc_calc.sv
// Module: forms the PC value to save; a delay-slot fault points back at its branch.
// Assumes fixed-size instructions of INSN_BYTES bytes.
module exc_epc_calc #(
    parameter int XLEN       = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic            in_delay_slot,
    output logic [XLEN-1:0] epc_val
);
    // Step back one instruction for a delay-slot fault.
    always_comb begin
        epc_val = in_delay_slot ? (cur_pc - XLEN'(INSN_BYTES)) : cur_pc;
    end
endmodule

// File: rtl/exc_state_regs.sv
// Module: holds the cause fields, the saved PC and the exception level.
// Assumes commit is already qualified (reset/NMI excluded) by the parent.
module exc_state_regs
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int CODE_W = 5,
    parameter int CE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              eret_clr,
    input  logic              bd_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CE_W-1:0]   ce_in,
    input  logic [XLEN-1:0]   epc_in,
    output logic              bd_q,
    output logic [CODE_W-1:0] code_q,
    output logic [CE_W-1:0]   ce_q,
    output logic [XLEN-1:0]   epc_q,
    output logic              exl_q
);
    // Cause fields: bd and code on every commit, ce only for coprocessor-unusable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bd_q   <= 1'b0;
            code_q <= '0;
            ce_q   <= '0;
        end else if (commit) begin
            bd_q   <= bd_in;
            code_q <= code_in;
            if (code_in == CODE_W'(EXC_CODE_CPU))
                ce_q <= ce_in;
        end
    end

    // Saved PC: written only when the level was clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc_q <= '0;
        else if (commit && !exl_q)
            epc_q <= epc_in;
    end

    // Exception level: set on commit, cleared by the return path otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exl_q <= 1'b0;
        else if (commit)
            exl_q <= 1'b1;
        else if (eret_clr)
            exl_q <= 1'b0;
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Top: exception entry. Redirects fetch in the request cycle and commits the
// cause, saved PC and level at the closing edge. Reset/NMI wins and only redirects.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int VEC_W      = 32,
    parameter int CODE_W     = 5,
    parameter int CE_W       = 2,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [CODE_W-1:0]  exc_code,
    input  logic [CE_W-1:0]    cop_num,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic               in_delay_slot,
    input  logic               tlb_refill,
    input  logic               mode64,
    input  logic               rst_nmi_req,
    input  logic               boot_vec_sel,
    input  logic               eret_clr,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    epc,
    output logic               exl,
    output logic [CAUSE_W-1:0] cause_word
);
    logic              commit;
    logic [XLEN-1:0]   epc_val;
    logic              bd_q;
    logic [CODE_W-1:0] code_q;
    logic [CE_W-1:0]   ce_q;

    // Accept an exception only when no reset/NMI competes.
    assign commit         = exc_req && !rst_nmi_req;
    assign redirect_valid = exc_req || rst_nmi_req;

    exc_vec_sel #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vec (
        .boot_vec_sel (boot_vec_sel),
        .exl_cur      (exl),
        .tlb_refill   (tlb_refill),
        .mode64       (mode64),
        .rst_nmi_req  (rst_nmi_req),
        .vec_out      (redirect_pc)
    );

    exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
        .cur_pc        (cur_pc),
        .in_delay_slot (in_delay_slot),
        .epc_val       (epc_val)
    );

    exc_state_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .CE_W(CE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .eret_clr (eret_clr),
        .bd_in    (in_delay_slot),
        .code_in  (exc_code),
        .ce_in    (cop_num),
        .epc_in   (epc_val),
        .bd_q     (bd_q),
        .code_q   (code_q),
        .ce_q     (ce_q),
        .epc_q    (epc),
        .exl_q    (exl)
    );

    // Assemble the cause image; unnamed bits read zero.
    always_comb begin
        cause_word = '0;
        cause_word[CAUSE_BD_BIT]              = bd_q;
        cause_word[CAUSE_CE_LSB +: CE_W]      = ce_q;
        cause_word[CAUSE_EC_LSB +: CODE_W]    = code_q;
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Checker: temporal properties of the exception entry unit, bound to the top.
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req,
    input logic [4:0]  exc_code,
    input logic [1:0]  cop_num,
    input logic [63:0] cur_pc,
    input logic        in_delay_slot,
    input logic        rst_nmi_req,
    input logic        eret_clr,
    input logic        redirect_valid,
    input logic [63:0] redirect_pc,
    input logic [63:0] epc,
    input logic        exl,
    input logic [31:0] cause_word
);
    // R2
    reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_nmi_req |-> (redirect_valid && redirect_pc == 64'hFFFF_FFFF_BFC0_0000));

    // R2
    reset_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_nmi_req && !eret_clr |=> ($stable(epc) && $stable(exl) && $stable(cause_word)));

    // R6
    epc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_nmi_req && !exl) |=>
            epc == ($past(in_delay_slot) ? $past(cur_pc) - 64'd4 : $past(cur_pc)));

    // R6
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_nmi_req && exl) |=> $stable(epc));

    // R7
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_nmi_req) |=> exl);

    // R5
    bd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_nmi_req) |=> cause_word[31] == $past(in_delay_slot));

    // R8
    code_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_nmi_req) |=> cause_word[6:2] == $past(exc_code));

    // R9
    ce_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_nmi_req && exc_code == 5'd11) |=> cause_word[29:28] == $past(cop_num));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && !rst_nmi_req && !eret_clr) |=>
            ($stable(epc) && $stable(exl) && $stable(cause_word)));

    // R12
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc[63:32] == {32{redirect_pc[31]}}));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req        (exc_req),
    .exc_code       (exc_code),
    .cop_num        (cop_num),
    .cur_pc         (cur_pc),
    .in_delay_slot  (in_delay_slot),
    .rst_nmi_req    (rst_nmi_req),
    .eret_clr       (eret_clr),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .exl            (exl),
    .cause_word     (cause_word)
);

// File: tb/tb_exc_entry_unit.sv
// Directed bench for the exception entry unit; one task per scenario.
module tb_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [1:0]  cop_num = '0;
    logic [63:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic        tlb_refill = 1'b0;
    logic        mode64 = 1'b0;
    logic        rst_nmi_req = 1'b0;
    logic        boot_vec_sel = 1'b0;
    logic        eret_clr = 1'b0;
    logic        redirect_valid;
    logic [63:0] redirect_pc;
    logic [63:0] epc;
    logic        exl;
    logic [31:0] cause_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench model of the architectural state.
    logic [63:0] m_epc = '0;
    logic        m_exl = 1'b0;
    logic        m_bd  = 1'b0;
    logic [4:0]  m_code = '0;
    logic [1:0]  m_ce  = '0;

    always #4 clk = ~clk;

    exc_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .cop_num(cop_num), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
        .tlb_refill(tlb_refill), .mode64(mode64), .rst_nmi_req(rst_nmi_req),
        .boot_vec_sel(boot_vec_sel), .eret_clr(eret_clr),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .epc(epc), .exl(exl), .cause_word(cause_word)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_vector(input logic bev, input logic lvl,
                                               input logic refill, input logic m64);
        logic [63:0] b;
        b = bev ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
        if (refill && !lvl) return m64 ? b + 64'h80 : b;
        return b + 64'h180;
    endfunction

    function automatic logic [31:0] exp_cause();
        return {m_bd, 1'b0, m_ce, 21'd0, m_code, 2'b00};
    endfunction

    // Drive one cycle of stimulus, check the redirect, clock, then check the state.
    task automatic fire(input logic req, input logic rnmi, input logic eret,
                        input logic [4:0] code, input logic [1:0] cop,
                        input logic [63:0] pc, input logic ds, input logic refill,
                        input logic m64, input logic bev,
                        input string vtag, input string stag);
        logic [63:0] ev;
        @(negedge clk);
        exc_req = req; rst_nmi_req = rnmi; eret_clr = eret; exc_code = code;
        cop_num = cop; cur_pc = pc; in_delay_slot = ds; tlb_refill = refill;
        mode64 = m64; boot_vec_sel = bev;
        #1;
        ev = rnmi ? 64'hFFFF_FFFF_BFC0_0000 : exp_vector(bev, m_exl, refill, m64);
        chk({vtag, " redirect_valid"}, 64'(redirect_valid), 64'(req | rnmi));
        if (req || rnmi) begin
            chk({vtag, " redirect_pc"}, redirect_pc, ev);
            chk("R12 sign extension", redirect_pc, {{32{redirect_pc[31]}}, redirect_pc[31:0]});
        end
        if (!rnmi && req) begin
            m_bd = ds; m_code = code;
            if (code == 5'd11) m_ce = cop;
            if (!m_exl) m_epc = ds ? pc - 64'd4 : pc;
            m_exl = 1'b1;
        end else if (!rnmi && eret) begin
            m_exl = 1'b0;
        end
        @(negedge clk);
        exc_req = 0; rst_nmi_req = 0; eret_clr = 0;
        chk({stag, " epc"}, epc, m_epc);
        chk({stag, " exl"}, 64'(exl), 64'(m_exl));
        chk({stag, " cause"}, 64'(cause_word), 64'(exp_cause()));
    endtask

    task automatic t_reset_state();
        #1;
        chk("R11 reset epc", epc, 64'd0);
        chk("R11 reset exl", 64'(exl), 64'd0);
        chk("R11 reset cause", 64'(cause_word), 64'd0);
        chk("R1 idle redirect_valid", 64'(redirect_valid), 64'd0);
    endtask

    task automatic t_interrupt();
        fire(1, 0, 0, 5'd0, 2'd0, 64'hFFFF_FFFF_8000_1234, 0, 0, 0, 0, "R1 R3", "R6 R7 R8");
    endtask

    task automatic t_nested_syscall();
        fire(1, 0, 0, 5'd8, 2'd0, 64'h0000_0000_0040_0100, 1, 0, 0, 0, "R3 nested", "R5 R6 R8 nested");
        chk("R8 code 8 image", 64'(cause_word[6:0]), 64'h20);
    endtask

    task automatic t_refill_normal();
        fire(0, 0, 1, 5'd0, 2'd0, 64'd0, 0, 0, 0, 0, "R1 eret", "R7 clear");
        fire(1, 0, 0, 5'd2, 2'd0, 64'h0000_0000_0001_0008, 1, 1, 0, 0, "R3 refill32", "R5 R6 delay slot");
        fire(1, 0, 0, 5'd3, 2'd0, 64'h0000_0000_0002_0000, 0, 1, 1, 0, "R3 refill at exl1", "R6 hold");
        fire(0, 0, 1, 5'd0, 2'd0, 64'd0, 0, 0, 0, 0, "R1 eret", "R7 clear");
        fire(1, 0, 0, 5'd3, 2'd0, 64'h0000_0000_0003_0000, 0, 1, 1, 0, "R3 refill64", "R6 R8 refill64");
    endtask

    task automatic t_boot_vectors();
        fire(0, 0, 1, 5'd0, 2'd0, 64'd0, 0, 0, 0, 1, "R1 eret", "R7 clear");
        fire(1, 0, 0, 5'd2, 2'd0, 64'h0000_0000_0004_0000, 0, 1, 0, 1, "R4 refill32", "R4 state");
        fire(1, 0, 0, 5'd4, 2'd0, 64'h0000_0000_0005_0000, 0, 0, 0, 1, "R4 general", "R4 state");
        fire(0, 0, 1, 5'd0, 2'd0, 64'd0, 0, 0, 0, 1, "R1 eret", "R7 clear");
        fire(1, 0, 0, 5'd2, 2'd0, 64'h0000_0000_0006_0000, 0, 1, 1, 1, "R4 refill64", "R4 state");
    endtask

    task automatic t_cop_field();
        fire(1, 0, 0, 5'd11, 2'd1, 64'h0000_0000_0007_0000, 0, 0, 0, 0, "R3 cpu", "R9 write ce");
        chk("R9 ce field", 64'(cause_word[29:28]), 64'd1);
        fire(1, 0, 0, 5'd12, 2'd3, 64'h0000_0000_0008_0000, 0, 0, 0, 0, "R3 ovf", "R9 hold ce");
        chk("R9 ce unchanged", 64'(cause_word[29:28]), 64'd1);
    endtask

    task automatic t_reset_nmi();
        fire(0, 1, 0, 5'd0, 2'd0, 64'h0000_0000_0009_0000, 0, 0, 0, 0, "R2 nmi alone", "R2 no state");
        fire(1, 1, 0, 5'd9, 2'd2, 64'h0000_0000_000A_0000, 1, 1, 1, 1, "R2 nmi wins", "R2 no state");
    endtask

    task automatic t_eret_race();
        fire(0, 0, 1, 5'd0, 2'd0, 64'd0, 0, 0, 0, 0, "R1 eret", "R7 clear");
        fire(1, 0, 1, 5'd13, 2'd0, 64'h0000_0000_000B_0000, 0, 0, 0, 0, "R3 race", "R7 exc beats clear");
    endtask

    task automatic t_idle();
        fire(0, 0, 0, 5'd15, 2'd3, 64'h0000_0000_000C_0000, 1, 1, 1, 1, "R10 idle", "R10 hold");
        fire(0, 0, 0, 5'd23, 2'd2, 64'h0000_0000_000D_0000, 0, 0, 0, 0, "R10 idle", "R10 hold");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_interrupt();
        t_nested_syscall();
        t_refill_normal();
        t_boot_vectors();
        t_cop_field();
        t_reset_nmi();
        t_eret_race();
        t_idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule